// File: doc/BRIEF.md
# Execute-Group Redirect Generator

This block sits at the tail of a multi-wide execute stage. Each cycle it looks at one group of up to `W` executed instruction slots, together with a memory-ordering violation flag from the load/store unit. It decides whether the group must redirect fetch. If it must, it builds a single squash record for the commit side. Slot 0 holds the oldest instruction and slot `W-1` the youngest. Only the oldest slot that triggers produces the record.

A slot can trigger in two ways. If it resolved as a mispredicted branch, it produces a branch redirect. The record then carries the branch address, the corrected next address and the real branch direction. That direction is recovered by comparing the next address against the sequential successor, which is the branch address plus 4. If the slot is not a mispredict but the load/store unit reports an ordering violation, the slot produces an ordering redirect. That record carries the slot's sequence number and next address, plus the sequence number of the violating load for dependence training.

The record is registered, so it appears one clock after its group. Two event counters track mispredicted branches that had been predicted taken, and ordering redirects.

Top module: `redir_gen`

## Requirements
- R1: When no slot triggers, `rd_valid` is low one cycle later, every record field (`rd_seq`, `rd_pc`, `rd_npc`, `rd_br_mispred`, `rd_taken`, `rd_viol_seq`) is zero, and both counters hold their values.
- R2: Slot i is considered older than slot i+1. When several slots trigger, only the lowest-indexed triggering slot forms the record, and at most one record is produced per group.
- R3: A branch redirect sets `rd_valid` and `rd_br_mispred`, and carries that slot's sequence number in `rd_seq`, its PC in `rd_pc` and its next PC in `rd_npc`. `rd_viol_seq` is zero.
- R4: On a branch redirect, `rd_taken` is 1 exactly when the slot's next PC differs from its PC plus 4. The addition wraps modulo 2^PC_W.
- R5: An ordering redirect sets `rd_valid`, and carries the slot's sequence number and next PC, with `rd_viol_seq` equal to `mem_viol_seq`. In this case `rd_br_mispred`, `rd_taken` and `rd_pc` are zero.
- R6: Within one slot, a mispredict takes precedence over an asserted ordering violation.
- R7: A slot whose valid bit is low, or whose squashed bit is high, never triggers. An ordering violation with no live slot produces no record.
- R8: The record appears on the clock edge after its group is presented and lasts one cycle. Back-to-back triggering groups give back-to-back records.
- R9: `cnt_taken_wrong` increments by one, at the same edge as the record, for each branch redirect whose slot had its predicted-taken bit set. It does not increment otherwise.
- R10: `cnt_mem_order` increments by one, at the same edge as the record, for each ordering redirect.
- R11: A synchronous active-high `rst` clears the record and both counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_valid | input | W | Slot holds an executed instruction (bit i = slot i) |
| slot_squashed | input | W | Slot's instruction is already squashed |
| slot_mispred | input | W | Slot resolved as a mispredicted branch |
| slot_pred_taken | input | W | Slot's branch had been predicted taken |
| slot_seq | input | W*SEQ_W | Sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| slot_pc | input | W*PC_W | Instruction addresses, slot i at [i*PC_W +: PC_W] |
| slot_npc | input | W*PC_W | Resolved next addresses, slot i at [i*PC_W +: PC_W] |
| mem_viol | input | 1 | Load/store unit reports an ordering violation this cycle |
| mem_viol_seq | input | SEQ_W | Sequence number of the violating load |
| rd_valid | output | 1 | Redirect/squash record valid |
| rd_seq | output | SEQ_W | Sequence number of the triggering instruction |
| rd_pc | output | PC_W | Mispredicted branch address (zero for ordering redirect) |
| rd_npc | output | PC_W | Corrected next fetch address |
| rd_br_mispred | output | 1 | Record is a branch mispredict |
| rd_taken | output | 1 | Actual branch direction |
| rd_viol_seq | output | SEQ_W | Violating load sequence number (ordering redirect) |
| cnt_taken_wrong | output | CNT_W | Count of mispredicted branches predicted taken |
| cnt_mem_order | output | CNT_W | Count of ordering redirects |

## Verification
A table of groups drives the block back to back. The groups use single and multiple mispredicts at different slot positions, which separates correct oldest-first selection from youngest-first or first-found errors. Some groups combine a mispredict in a young slot with a violation, so that an older live slot wins. That shows the violation attaches to the oldest live slot, not to the mispredicting one. Squashed and invalid slots sit in front of triggering ones to expose a skip that ignores either bit. Groups with all slots dead, or with no trigger, confirm nothing fires. Next addresses are chosen both equal to and distinct from the sequential successor. Directed cases add an address that wraps at the top of the space, a reset arriving together with a triggering group, and an idle cycle that must drop the record.

// File: rtl/redir_pkg.sv
package redir_pkg;
    // Trigger classification of one execute slot
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_BRANCH = 2'd1,
        RK_MEMORD = 2'd2
    } redir_kind_e;
endpackage

// File: rtl/redir_slot_eval.sv
module redir_slot_eval
    import redir_pkg::*;
(
    input  logic        valid,
    input  logic        squashed,
    input  logic        mispred,
    input  logic        mem_viol,
    output redir_kind_e kind
);
    always_comb begin
        kind = RK_NONE;
        if (valid && !squashed) begin
            // branch mispredict outranks an ordering violation
            if (mispred) begin
                kind = RK_BRANCH;
            end else if (mem_viol) begin
                kind = RK_MEMORD;
            end
        end
    end
endmodule

// File: rtl/redir_oldest_pick.sv
module redir_oldest_pick
    import redir_pkg::*;
#(
    parameter int W     = 4,
    parameter int IDX_W = 2
) (
    input  logic [2*W-1:0]   kinds_flat,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output redir_kind_e      kind
);
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        kind = RK_NONE;
        // walk youngest to oldest so the oldest trigger is left standing
        for (int i = W - 1; i >= 0; i--) begin
            if (kinds_flat[2*i +: 2] != 2'b00) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                kind = redir_kind_e'(kinds_flat[2*i +: 2]);
            end
        end
    end
endmodule

// File: rtl/redir_gen.sv
module redir_gen
    import redir_pkg::*;
#(
    parameter int W          = 4,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int INST_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       slot_valid,
    input  logic [W-1:0]       slot_squashed,
    input  logic [W-1:0]       slot_mispred,
    input  logic [W-1:0]       slot_pred_taken,
    input  logic [W*SEQ_W-1:0] slot_seq,
    input  logic [W*PC_W-1:0]  slot_pc,
    input  logic [W*PC_W-1:0]  slot_npc,
    input  logic               mem_viol,
    input  logic [SEQ_W-1:0]   mem_viol_seq,
    output logic               rd_valid,
    output logic [SEQ_W-1:0]   rd_seq,
    output logic [PC_W-1:0]    rd_pc,
    output logic [PC_W-1:0]    rd_npc,
    output logic               rd_br_mispred,
    output logic               rd_taken,
    output logic [SEQ_W-1:0]   rd_viol_seq,
    output logic [CNT_W-1:0]   cnt_taken_wrong,
    output logic [CNT_W-1:0]   cnt_mem_order
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic             vld;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic             br;
        logic             taken;
        logic [SEQ_W-1:0] viol_seq;
        logic [CNT_W-1:0] cnt_tw;
        logic [CNT_W-1:0] cnt_mem;
    } state_t;

    state_t st_d, st_q;

    logic [2*W-1:0]   kinds_flat;
    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;
    redir_kind_e      pick_kind;

    for (genvar g = 0; g < W; g++) begin : g_slot
        redir_kind_e kind_g;
        redir_slot_eval u_eval (
            .valid    (slot_valid[g]),
            .squashed (slot_squashed[g]),
            .mispred  (slot_mispred[g]),
            .mem_viol (mem_viol),
            .kind     (kind_g)
        );
        assign kinds_flat[2*g +: 2] = kind_g;
    end

    redir_oldest_pick #(.W(W), .IDX_W(IDX_W)) u_pick (
        .kinds_flat (kinds_flat),
        .hit        (pick_hit),
        .idx        (pick_idx),
        .kind       (pick_kind)
    );

    logic [SEQ_W-1:0] sel_seq;
    logic [PC_W-1:0]  sel_pc;
    logic [PC_W-1:0]  sel_npc;
    logic             sel_pt;

    always_comb begin
        sel_seq = slot_seq[pick_idx*SEQ_W +: SEQ_W];
        sel_pc  = slot_pc[pick_idx*PC_W +: PC_W];
        sel_npc = slot_npc[pick_idx*PC_W +: PC_W];
        sel_pt  = slot_pred_taken[pick_idx];
    end

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.seq      = '0;
        st_d.pc       = '0;
        st_d.npc      = '0;
        st_d.br       = 1'b0;
        st_d.taken    = 1'b0;
        st_d.viol_seq = '0;
        if (pick_hit) begin
            st_d.vld = 1'b1;
            st_d.seq = sel_seq;
            st_d.npc = sel_npc;
            if (pick_kind == RK_BRANCH) begin
                st_d.br    = 1'b1;
                st_d.pc    = sel_pc;
                st_d.taken = (sel_npc != (sel_pc + PC_W'(INST_BYTES)));
                if (sel_pt) begin
                    st_d.cnt_tw = st_q.cnt_tw + CNT_W'(1);
                end
            end else begin
                st_d.viol_seq = mem_viol_seq;
                st_d.cnt_mem  = st_q.cnt_mem + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid        = st_q.vld;
    assign rd_seq          = st_q.seq;
    assign rd_pc           = st_q.pc;
    assign rd_npc          = st_q.npc;
    assign rd_br_mispred   = st_q.br;
    assign rd_taken        = st_q.taken;
    assign rd_viol_seq     = st_q.viol_seq;
    assign cnt_taken_wrong = st_q.cnt_tw;
    assign cnt_mem_order   = st_q.cnt_mem;
endmodule

// File: rtl/redir_gen_chk.sv
module redir_gen_chk #(
    parameter int W          = 4,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int INST_BYTES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     slot_valid,
    input logic [W-1:0]     slot_squashed,
    input logic             rd_valid,
    input logic [PC_W-1:0]  rd_pc,
    input logic [PC_W-1:0]  rd_npc,
    input logic             rd_br_mispred,
    input logic             rd_taken,
    input logic [CNT_W-1:0] cnt_taken_wrong,
    input logic [CNT_W-1:0] cnt_mem_order
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r3_br_implies_valid: assert property (@(posedge clk) disable iff (rst)
        rd_br_mispred |-> rd_valid);

    a_r4_taken_dir: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_br_mispred) |-> (rd_taken == (rd_npc != rd_pc + PC_W'(INST_BYTES))));

    a_r5_mem_no_branch_info: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_br_mispred) |-> (rd_pc == '0 && !rd_taken));

    a_r7_needs_live_slot: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_valid) |-> $past(|(slot_valid & ~slot_squashed)));

    a_r9_tw_only_on_branch: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cnt_taken_wrong != $past(cnt_taken_wrong)) |-> (rd_valid && rd_br_mispred));

    a_r10_mem_count_step: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_valid && !rd_br_mispred) |-> (cnt_mem_order == $past(cnt_mem_order) + CNT_W'(1)));

    a_r1_idle_holds_counts: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_valid) |-> ($stable(cnt_mem_order) && $stable(cnt_taken_wrong)));
endmodule

bind redir_gen redir_gen_chk #(.W(W), .PC_W(PC_W), .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)) u_chk (.*);

// File: tb/redir_gen_tb.sv
`timescale 1ns/1ps
module redir_gen_tb;
    localparam int W = 4, SEQ_W = 16, PC_W = 32, CNT_W = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [W-1:0] slot_valid = '0, slot_squashed = '0, slot_mispred = '0, slot_pred_taken = '0;
    logic [W*SEQ_W-1:0] slot_seq = '0;
    logic [W*PC_W-1:0]  slot_pc = '0, slot_npc = '0;
    logic mem_viol = 1'b0;
    logic [SEQ_W-1:0] mem_viol_seq = '0;
    logic rd_valid, rd_br_mispred, rd_taken;
    logic [SEQ_W-1:0] rd_seq, rd_viol_seq;
    logic [PC_W-1:0] rd_pc, rd_npc;
    logic [CNT_W-1:0] cnt_taken_wrong, cnt_mem_order;

    always #2 clk = ~clk;

    redir_gen u_dut (.*);

    typedef struct packed {
        logic [3:0] v, sq, mp, pt, far;
        logic       mv;
        logic [1:0] ek;   // 0 none, 1 branch, 2 ordering
        logic [1:0] es;   // expected slot
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 2'd0},
        '{4'b1111, 4'b0000, 4'b0100, 4'b0100, 4'b0100, 1'b0, 2'd1, 2'd2},
        '{4'b1111, 4'b0000, 4'b0110, 4'b0000, 4'b0000, 1'b0, 2'd1, 2'd1},
        '{4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, 2'd0},
        '{4'b1111, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, 2'd2},
        '{4'b1111, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd2, 2'd1},
        '{4'b1111, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 1'b1, 2'd1, 2'd0},
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, 2'd0},
        '{4'b1010, 4'b0010, 4'b1000, 4'b1000, 4'b1000, 1'b0, 2'd1, 2'd3},
        '{4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd0, 2'd0},
        '{4'b1111, 4'b0000, 4'b0010, 4'b0000, 4'b0010, 1'b0, 2'd1, 2'd1}
    };

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [CNT_W-1:0] exp_tw = '0, exp_mem = '0;

    function automatic logic [PC_W-1:0] pc_of(int n, int i);
        return 32'h1000 + PC_W'(n * 256 + i * 16);
    endfunction
    function automatic logic [PC_W-1:0] npc_of(int n, int i, logic far);
        return far ? pc_of(n, i) + 32'h40 : pc_of(n, i) + 32'h4;
    endfunction
    function automatic logic [SEQ_W-1:0] seq_of(int n, int i);
        return SEQ_W'(n * 8 + i + 1);
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_vec(int n);
        vec_t t = VECS[n];
        slot_valid = t.v; slot_squashed = t.sq; slot_mispred = t.mp;
        slot_pred_taken = t.pt; mem_viol = t.mv;
        mem_viol_seq = 16'h0F00 + SEQ_W'(n);
        for (int i = 0; i < W; i++) begin
            slot_seq[i*SEQ_W +: SEQ_W] = seq_of(n, i);
            slot_pc[i*PC_W +: PC_W]    = pc_of(n, i);
            slot_npc[i*PC_W +: PC_W]   = npc_of(n, i, t.far[i]);
        end
    endtask

    task automatic check_vec(int n);
        vec_t t = VECS[n];
        int s = int'(t.es);
        string rq;
        if (t.ek == 2'd0) begin
            rq = (t.mv) ? "R7" : "R1";
            chk(rq, "valid", 64'(rd_valid), 0);
            chk(rq, "seq", 64'(rd_seq), 0);
            chk(rq, "npc", 64'(rd_npc), 0);
            chk("R1", "cnt_tw", 64'(cnt_taken_wrong), 64'(exp_tw));
            chk("R1", "cnt_mem", 64'(cnt_mem_order), 64'(exp_mem));
        end else if (t.ek == 2'd1) begin
            if (t.pt[s]) exp_tw++;
            chk("R8", "valid", 64'(rd_valid), 1);
            chk("R2", "seq", 64'(rd_seq), 64'(seq_of(n, s)));
            chk("R3", "pc", 64'(rd_pc), 64'(pc_of(n, s)));
            chk("R3", "npc", 64'(rd_npc), 64'(npc_of(n, s, t.far[s])));
            chk(t.mv ? "R6" : "R3", "br", 64'(rd_br_mispred), 1);
            chk("R4", "taken", 64'(rd_taken), 64'(t.far[s]));
            chk("R3", "viol_seq", 64'(rd_viol_seq), 0);
            chk("R9", "cnt_tw", 64'(cnt_taken_wrong), 64'(exp_tw));
        end else begin
            exp_mem++;
            chk("R8", "valid", 64'(rd_valid), 1);
            chk("R2", "seq", 64'(rd_seq), 64'(seq_of(n, s)));
            chk("R5", "npc", 64'(rd_npc), 64'(npc_of(n, s, t.far[s])));
            chk("R5", "br", 64'(rd_br_mispred), 0);
            chk("R5", "pc", 64'(rd_pc), 0);
            chk("R5", "taken", 64'(rd_taken), 0);
            chk("R5", "viol_seq", 64'(rd_viol_seq), 64'(16'h0F00 + n));
            chk("R10", "cnt_mem", 64'(cnt_mem_order), 64'(exp_mem));
        end
    endtask

    task automatic drive_idle();
        slot_valid = '0; slot_squashed = '0; slot_mispred = '0;
        slot_pred_taken = '0; mem_viol = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "valid", 64'(rd_valid), 0);
        chk("R11", "cnt_tw", 64'(cnt_taken_wrong), 0);
        chk("R11", "cnt_mem", 64'(cnt_mem_order), 0);
        rst = 1'b0;

        // table walk, groups back to back
        drive_vec(0);
        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            check_vec(n);
            if (n + 1 < NV) drive_vec(n + 1);
        end

        // R8: record drops after one cycle when idle follows
        drive_idle();
        @(negedge clk);
        chk("R8", "valid after idle", 64'(rd_valid), 0);
        chk("R1", "cnt_tw hold", 64'(cnt_taken_wrong), 64'(exp_tw));
        chk("R1", "cnt_mem hold", 64'(cnt_mem_order), 64'(exp_mem));

        // R4 corner: PC at top of space, sequential successor wraps to 0
        slot_valid = 4'b0001; slot_mispred = 4'b0001; slot_pred_taken = 4'b0001;
        slot_pc[0 +: PC_W] = 32'hFFFF_FFFC; slot_npc[0 +: PC_W] = 32'h0000_0000;
        @(negedge clk);
        exp_tw++;
        chk("R4", "wrap taken", 64'(rd_taken), 0);
        chk("R3", "wrap pc", 64'(rd_pc), 64'h0000_0000_FFFF_FFFC);
        chk("R9", "wrap cnt_tw", 64'(cnt_taken_wrong), 64'(exp_tw));

        // R11: reset together with a triggering group
        slot_valid = 4'b1111; mem_viol = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R11", "valid in reset", 64'(rd_valid), 0);
        chk("R11", "cnt_tw cleared", 64'(cnt_taken_wrong), 0);
        chk("R11", "cnt_mem cleared", 64'(cnt_mem_order), 0);
        rst = 1'b0;
        drive_idle();
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule